// File: doc/BRIEF.md
# Streaming 3x3 Multi-Channel Convolver with Fixed-Point Requantization

This block takes a raster stream of 8-bit signed pixels and runs a 3x3 convolution over it. Each beat carries one pixel from every input channel. Each channel keeps two previous lines on chip and a 3x3 sliding window, so every incoming pixel is reused by all windows that cover it. Every channel has its own 3x3 kernel. The nine products of all channels are summed in a 24-bit accumulator, together with one 8-bit bias that is left-shifted to line up with the accumulator's binary point. The sum is then shifted right by a per-layer amount, rounded half-up, clamped back to 8 bits with its sign kept, and optionally passed through a rectifier.

A 1x1 kernel runs on the same engine by loading only the centre tap and leaving the other eight at zero. A larger kernel is split into several 3x3 passes, and software adds up their results. Kernels and bias are written through a small parameter port. The line width, bias shift, output shift and rectifier enable are static configuration inputs. They are changed only while no frame is in flight. Windows that would run past the image edge produce no output.

Top module: `conv3_stream`

## Requirements
- R1: After synchronous reset, out_valid is 0 and in_ready is 1, and all weights and the bias read as zero.
- R2: A beat is accepted when in_valid and in_ready are both 1. A beat with in_sof set is row 0, column 0 of a new frame, and positions then advance column by column, wrapping to the next row after cfg_width pixels. An output is produced for an accepted pixel only when its row is at least 2 and its column is at least 2, so a W by H frame yields exactly (W-2)*(H-2) outputs.
- R3: The output for the pixel at (r,c) uses the window of rows r-2..r and columns c-2..c. Tap index t = 3*i + j, where i is the row offset from the oldest row (0 = r-2) and j is the column offset from the leftmost column (0 = c-2). The products pixel*weight of every channel and every tap are summed. Channel k occupies in_pix bits [8k+7:8k].
- R4: The 8-bit signed bias, shifted left by cfg_bias_shift, is added to the sum. The total is held as a 24-bit two's-complement value.
- R5: Requantization computes (acc + 2^(s-1)) >> s with an arithmetic shift, where s = cfg_out_shift. When s = 0 the value passes through unrounded.
- R6: A requantized value above 127 becomes 127, and one below -128 becomes -128. A non-negative accumulator never yields a negative output, and magnitudes that round below one step yield 0.
- R7: When cfg_relu is 1, negative results after saturation are output as 0. When cfg_relu is 0, they pass unchanged.
- R8: An output appears exactly CONV_LAT = 3 cycles after the edge that accepts the window's last pixel: accepted at edge k, out_valid is high in the cycle after edge k+2. Outputs arrive in acceptance order.
- R9: Parameter writes use prm_addr = 9*channel + tap for weights and prm_addr = 9*NCH for the bias. While prm_we is 1, in_ready is 0 and the offered pixel is not consumed. Each output uses the parameters in force when its last pixel was accepted.
- R10: A kernel whose only nonzero tap is the centre (tap 4) acts as a 1x1 convolution of the pixel at (r-1,c-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | 7 | Line width in pixels (3..MAX_W) |
| cfg_bias_shift | input | 4 | Left shift applied to the bias |
| cfg_out_shift | input | 4 | Right shift applied before rounding and clamping |
| cfg_relu | input | 1 | Rectifier enable |
| prm_we | input | 1 | Parameter write strobe |
| prm_addr | input | 5 | Weight or bias address |
| prm_data | input | 8 | Signed weight or bias value |
| in_valid | input | 1 | Pixel beat valid |
| in_sof | input | 1 | Beat is the first pixel of a frame |
| in_pix | input | 16 | Packed pixels, one byte per channel |
| in_ready | output | 1 | Beat can be accepted |
| out_valid | output | 1 | Result valid |
| out_data | output | 8 | Signed requantized result |

## Verification
A parameter write and a pixel offer can fall in the same cycle. At the same time, an earlier window may still be inside the multiply stage when the new weight lands. The bench raises prm_we while holding in_valid with a pixel mid-frame, then offers the same pixel again. A behavioural model predicts each result from the weights in force at acceptance, so a window in flight must still show the old weight, the stalled pixel must be taken exactly once, and later windows must show the new one.

// File: rtl/conv3_pkg.sv
package conv3_pkg;
    localparam int PIX_W    = 8;
    localparam int ACC_W    = 24;
    localparam int TAPS     = 9;
    localparam int SH_W     = 4;
    localparam int CONV_LAT = 3;

    typedef logic signed [PIX_W-1:0] pix_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    // arithmetic right shift with half-up rounding and sign-keeping clamp
    function automatic pix_t requant(input acc_t a, input logic [SH_W-1:0] s);
        logic signed [ACC_W:0] w;
        logic signed [ACC_W:0] r;
        w = {a[ACC_W-1], a};
        if (s != '0)
            w = w + ((ACC_W+1)'(1) <<< (s - SH_W'(1)));
        r = w >>> s;
        if (r > (ACC_W+1)'(127))
            return pix_t'(127);
        else if (r < -(ACC_W+1)'(128))
            return pix_t'(-128);
        else
            return pix_t'(r[PIX_W-1:0]);
    endfunction
endpackage

// File: rtl/conv3_linebuf.sv
module conv3_linebuf
    import conv3_pkg::*;
#(
    parameter int MAX_W = 64,
    localparam int IW = $clog2(MAX_W)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         fire,
    input  logic [IW-1:0]                col,
    input  logic [PIX_W-1:0]             pix,
    output logic [TAPS-1:0][PIX_W-1:0]   win_o
);
    logic [PIX_W-1:0] line_up1 [MAX_W];
    logic [PIX_W-1:0] line_up2 [MAX_W];

    always_ff @(posedge clk) begin
        if (fire) begin
            line_up2[col] <= line_up1[col];
            line_up1[col] <= pix;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_o <= '0;
        end else if (fire) begin
            for (int i = 0; i < 3; i++) begin
                win_o[3*i]   <= win_o[3*i+1];
                win_o[3*i+1] <= win_o[3*i+2];
            end
            win_o[2] <= line_up2[col];
            win_o[5] <= line_up1[col];
            win_o[8] <= pix;
        end
    end
endmodule

// File: rtl/conv3_mac.sv
module conv3_mac
    import conv3_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 win_vld,
    input  logic [NCH-1:0][TAPS-1:0][PIX_W-1:0]  win,
    input  logic [NCH-1:0][TAPS-1:0][PIX_W-1:0]  wgt,
    input  logic [PIX_W-1:0]                     bias,
    input  logic [SH_W-1:0]                      bias_shift,
    output logic                                 acc_vld,
    output acc_t                                 acc
);
    acc_t sum;

    always_comb begin
        sum = {{(ACC_W-PIX_W){bias[PIX_W-1]}}, bias};
        sum = sum <<< bias_shift;
        for (int ch = 0; ch < NCH; ch++) begin
            for (int t = 0; t < TAPS; t++) begin
                sum = sum + ($signed(win[ch][t]) * $signed(wgt[ch][t]));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_vld <= 1'b0;
            acc     <= '0;
        end else begin
            acc_vld <= win_vld;
            if (win_vld) acc <= sum;
        end
    end

    assert_window_to_sum_R8: assert property (@(posedge clk) disable iff (rst)
        win_vld |=> acc_vld);
endmodule

// File: rtl/conv3_requant.sv
module conv3_requant
    import conv3_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_vld,
    input  acc_t             acc,
    input  logic [SH_W-1:0]  out_shift,
    input  logic             relu,
    output logic             out_vld,
    output logic [PIX_W-1:0] out_data
);
    pix_t clamped;
    pix_t rectified;

    always_comb begin
        clamped   = requant(acc, out_shift);
        rectified = (relu && clamped[PIX_W-1]) ? pix_t'(0) : clamped;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_data <= '0;
        end else begin
            out_vld <= acc_vld;
            if (acc_vld) out_data <= rectified;
        end
    end

    assert_sum_to_output_R8: assert property (@(posedge clk) disable iff (rst)
        acc_vld |=> out_vld);

    assert_relu_nonneg_R7: assert property (@(posedge clk) disable iff (rst)
        (out_vld && $past(relu)) |-> !out_data[PIX_W-1]);

    assert_sign_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !$past(acc[ACC_W-1])) |-> !out_data[PIX_W-1]);
endmodule

// File: rtl/conv3_stream.sv
module conv3_stream
    import conv3_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int MAX_W = 64,
    localparam int WW = $clog2(MAX_W+1),
    localparam int IW = $clog2(MAX_W),
    localparam int AW = $clog2(NCH*TAPS+1),
    localparam int PW = NCH*PIX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WW-1:0]    cfg_width,
    input  logic [SH_W-1:0]  cfg_bias_shift,
    input  logic [SH_W-1:0]  cfg_out_shift,
    input  logic             cfg_relu,
    input  logic             prm_we,
    input  logic [AW-1:0]    prm_addr,
    input  logic [PIX_W-1:0] prm_data,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [PW-1:0]    in_pix,
    output logic             in_ready,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_data
);
    logic                                fire;
    logic [WW-1:0]                       col_q, cur_col;
    logic [1:0]                          row_q, cur_row;
    logic                                win_vld_q;
    logic [NCH-1:0][TAPS-1:0][PIX_W-1:0] win_all;
    logic [NCH-1:0][TAPS-1:0][PIX_W-1:0] wgt_q;
    logic [PIX_W-1:0]                    bias_q;
    logic                                acc_vld;
    acc_t                                acc;

    assign in_ready = !prm_we;
    assign fire     = in_valid && in_ready;

    always_comb begin
        cur_col = in_sof ? '0 : col_q;
        cur_row = in_sof ? 2'd0 : row_q;
    end

    // raster position of the incoming beat; row saturates at 2
    always_ff @(posedge clk) begin
        if (rst) begin
            col_q     <= '0;
            row_q     <= 2'd0;
            win_vld_q <= 1'b0;
        end else begin
            win_vld_q <= fire && (cur_row == 2'd2) && (cur_col >= WW'(2));
            if (fire) begin
                if (cur_col == cfg_width - WW'(1)) begin
                    col_q <= '0;
                    row_q <= (cur_row == 2'd2) ? 2'd2 : cur_row + 2'd1;
                end else begin
                    col_q <= cur_col + WW'(1);
                    row_q <= cur_row;
                end
            end
        end
    end

    // kernel and bias storage
    always_ff @(posedge clk) begin
        if (rst) begin
            wgt_q  <= '0;
            bias_q <= '0;
        end else if (prm_we) begin
            for (int ch = 0; ch < NCH; ch++) begin
                for (int t = 0; t < TAPS; t++) begin
                    if (prm_addr == AW'(ch*TAPS + t)) wgt_q[ch][t] <= prm_data;
                end
            end
            if (prm_addr == AW'(NCH*TAPS)) bias_q <= prm_data;
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        conv3_linebuf #(.MAX_W(MAX_W)) u_lb (
            .clk   (clk),
            .rst   (rst),
            .fire  (fire),
            .col   (cur_col[IW-1:0]),
            .pix   (in_pix[ch*PIX_W +: PIX_W]),
            .win_o (win_all[ch])
        );
    end

    conv3_mac #(.NCH(NCH)) u_mac (
        .clk        (clk),
        .rst        (rst),
        .win_vld    (win_vld_q),
        .win        (win_all),
        .wgt        (wgt_q),
        .bias       (bias_q),
        .bias_shift (cfg_bias_shift),
        .acc_vld    (acc_vld),
        .acc        (acc)
    );

    conv3_requant u_rq (
        .clk       (clk),
        .rst       (rst),
        .acc_vld   (acc_vld),
        .acc       (acc),
        .out_shift (cfg_out_shift),
        .relu      (cfg_relu),
        .out_vld   (out_valid),
        .out_data  (out_data)
    );

    assert_output_follows_accept_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(fire, CONV_LAT));

    assert_output_needs_inner_window_R2: assert property (@(posedge clk) disable iff (rst)
        win_vld_q |-> $past(fire));
endmodule

// File: tb/conv3_stream_tb.sv
module conv3_stream_tb_top;
    import conv3_pkg::*;

    typedef struct { int val; int due; } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  cfg_width = 7'd6;
    logic [3:0]  cfg_bias_shift = '0;
    logic [3:0]  cfg_out_shift = '0;
    logic        cfg_relu = 1'b0;
    logic        prm_we = 1'b0;
    logic [4:0]  prm_addr = '0;
    logic [7:0]  prm_data = '0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [15:0] in_pix = '0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int out_cnt = 0;
    int seed = 12345;
    bit done = 0;
    string cur_req = "R3";

    int w[2][9];
    int bb = 0;
    int img[2][32][64];
    int mr = 0, mc = 0;
    exp_t q[$];

    conv3_stream dut_i (
        .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_bias_shift(cfg_bias_shift),
        .cfg_out_shift(cfg_out_shift), .cfg_relu(cfg_relu), .prm_we(prm_we),
        .prm_addr(prm_addr), .prm_data(prm_data), .in_valid(in_valid), .in_sof(in_sof),
        .in_pix(in_pix), .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int rnd(int lo, int hi);
        seed = seed * 1103515245 + 12345;
        return lo + (((seed >>> 16) & 32'h7fff) % (hi - lo + 1));
    endfunction

    function automatic int sx8(int v);
        v = v & 255;
        return (v >= 128) ? v - 256 : v;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int model_out(int r, int c);
        longint s;
        longint v;
        s = longint'(bb) <<< cfg_bias_shift;
        for (int ch = 0; ch < 2; ch++)
            for (int i = 0; i < 3; i++)
                for (int j = 0; j < 3; j++)
                    s += img[ch][r-2+i][c-2+j] * w[ch][3*i+j];
        s = s & 64'hFFFFFF;
        if (s >= 64'h800000) s -= 64'h1000000;
        v = s;
        if (cfg_out_shift != 0) v += (longint'(1) <<< (cfg_out_shift - 1));
        v = v >>> cfg_out_shift;
        if (v > 127) v = 127;
        if (v < -128) v = -128;
        if (cfg_relu && v < 0) v = 0;
        return int'(v);
    endfunction

    task automatic model_accept(bit sof, int p0, int p1);
        exp_t e;
        if (sof) begin mr = 0; mc = 0; end
        if (mr < 32) begin
            img[0][mr][mc] = p0;
            img[1][mr][mc] = p1;
        end
        if (mr >= 2 && mc >= 2 && mr < 32) begin
            e.val = model_out(mr, mc);
            e.due = cyc + CONV_LAT;
            q.push_back(e);
        end
        if (mc == int'(cfg_width) - 1) begin mc = 0; mr++; end
        else mc++;
    endtask

    // one bus cycle; returns whether the pixel was taken
    task automatic drive(input bit v, input bit sof, input int p0, input int p1,
                         input bit we, input int addr, input int data, output bit took);
        @(negedge clk);
        in_valid = v;
        in_sof   = sof;
        in_pix   = {8'(p1), 8'(p0)};
        prm_we   = we;
        prm_addr = 5'(addr);
        prm_data = 8'(data);
        #1;
        took = 0;
        if (v && we) check(in_ready == 1'b0, "R9", int'(in_ready), 0);
        if (v && in_ready) begin
            model_accept(sof, p0, p1);
            took = 1;
        end
        if (we) begin
            if (addr < 18) w[addr/9][addr%9] = sx8(data);
            else bb = sx8(data);
        end
    endtask

    task automatic idle(int n);
        bit t;
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, t);
    endtask

    task automatic load(int addr, int data);
        bit t;
        drive(0, 0, 0, 0, 1, addr, data, t);
    endtask

    task automatic run_frame(int W, int H, int plo, int phi, bit gaps, int wr_at);
        bit t;
        int n;
        n = 0;
        cfg_width = 7'(W);
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                int p0, p1;
                p0 = rnd(plo, phi);
                p1 = rnd(plo, phi);
                if (gaps && (c % 3 == 1)) idle(1);
                if (n == wr_at) begin
                    drive(1, (r == 0 && c == 0), p0, p1, 1, 4, 77, t);
                    check(t == 0, "R9", int'(t), 0);
                end
                drive(1, (r == 0 && c == 0), p0, p1, 0, 0, 0, t);
                n++;
            end
        end
        idle(6);
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                out_cnt++;
                if (q.size() == 0) begin
                    check(0, cur_req, sx8(out_data), -999);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(sx8(out_data) == e.val, cur_req, sx8(out_data), e.val);
                    check(e.due == cyc, "R8", cyc, e.due);
                end
            end else if (q.size() > 0 && q[0].due <= cyc) begin
                check(0, "R8", cyc, q[0].due);
                void'(q.pop_front());
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        for (int ch = 0; ch < 2; ch++) for (int t = 0; t < 9; t++) w[ch][t] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1", int'(in_ready), 1);
        // R1: zero parameters give zero outputs
        cur_req = "R1";
        out_cnt = 0;
        run_frame(4, 3, -128, 127, 0, -1);
        check(out_cnt == 2, "R1", out_cnt, 2);

        // R3 R4 R5: general kernels, bias and rounding
        for (int a = 0; a < 18; a++) load(a, rnd(-8, 8));
        load(18, 37);
        cfg_bias_shift = 4'd3;
        cfg_out_shift  = 4'd7;
        cur_req = "R3";
        out_cnt = 0;
        run_frame(6, 5, -128, 127, 0, -1);
        check(out_cnt == 12, "R2", out_cnt, 12);
        cur_req = "R4";
        load(18, -90);
        cfg_bias_shift = 4'd9;
        run_frame(5, 4, -20, 20, 0, -1);
        cur_req = "R5";
        cfg_out_shift = 4'd3;
        run_frame(7, 4, -30, 30, 0, -1);

        // R2: gaps in the stream and a frame restarted mid-row
        cur_req = "R2";
        out_cnt = 0;
        begin
            bit t;
            cfg_width = 7'd5;
            for (int i = 0; i < 8; i++) drive(1, (i == 0), rnd(-50, 50), rnd(-50, 50), 0, 0, 0, t);
        end
        run_frame(5, 4, -128, 127, 1, -1);
        check(out_cnt == 6, "R2", out_cnt, 6);

        // R6: saturation both ways, then underflow to zero
        cur_req = "R6";
        for (int a = 0; a < 18; a++) load(a, (a < 9) ? 127 : -128);
        load(18, 0);
        cfg_out_shift = 4'd0;
        run_frame(6, 5, -128, 127, 0, -1);
        cfg_out_shift = 4'd15;
        for (int a = 0; a < 18; a++) load(a, rnd(-2, 2));
        run_frame(6, 4, -10, 10, 0, -1);

        // R7: rectifier on
        cur_req = "R7";
        for (int a = 0; a < 18; a++) load(a, rnd(-8, 8));
        cfg_out_shift = 4'd5;
        cfg_relu = 1'b1;
        run_frame(6, 5, -128, 127, 0, -1);
        cfg_relu = 1'b0;

        // R10: 1x1 through the centre tap
        cur_req = "R10";
        for (int a = 0; a < 18; a++) load(a, (a == 4) ? 1 : 0);
        cfg_out_shift = 4'd0;
        cfg_bias_shift = 4'd0;
        run_frame(6, 4, -128, 127, 0, -1);

        // R9: weight write collides with an offered pixel mid-frame
        cur_req = "R9";
        for (int a = 0; a < 18; a++) load(a, rnd(-6, 6));
        cfg_out_shift = 4'd4;
        out_cnt = 0;
        run_frame(6, 5, -128, 127, 0, 15);
        check(out_cnt == 12, "R9", out_cnt, 12);
        check(q.size() == 0, "R8", q.size(), 0);

        finish_run();
    end
endmodule